// File: doc/BRIEF.md
# External Memory Bus Controller with Byte-Wide SRAM Mode

This controller sits between an internal 16-bit requester and an external asynchronous memory bus. The requester offers a word address, a read or write flag and write data. The controller decodes the address to decide which external device is involved. It then runs a bus cycle whose strobes are counted in whole clocks of the internal clock. For a read, it returns the assembled word with a one-clock response pulse. The external bus carries a 21-bit word address, a 16-bit data path with a drive enable, two chip selects (ROM and RAM), an output strobe, a write strobe and a byte-lane select. All chip selects and strobes are active low.

Two devices can be attached to the RAM chip select: a native 16-bit part, or an 8-bit SRAM. In the 8-bit case each word is moved as two byte transfers on data lines 7:0, and the byte-lane select chooses the half. The ROM chip select always runs word cycles. When the ROM pins are enabled, accesses to the internal ROM/Flash range below the ROM window also pulse the ROM chip select, and the data that comes back is thrown away. Addresses that fall in neither window finish at once and touch no pin.

The request side is a valid/ready pair. `req_ready` is high only while no cycle is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must keep its payload stable while it waits. The response cannot be stalled: `rsp_valid` is a single-clock pulse and must be consumed in that clock.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both chip selects, the output strobe, the write strobe and the byte-lane select are high, `bus_doe` and `rsp_valid` are low, and `req_ready` is high.
- R2: Word addresses 0x000E000 to 0x01FFFFF (when ROM pins are enabled) select the ROM chip select. Addresses 0x2000000 to 0x21FFFFF select the RAM chip select. The two chip selects are never low together.
- R3: An address outside both windows, and not shadowed under R4, asserts no chip select or strobe. `rsp_valid` is high in the first clock after acceptance, with `rsp_rdata` equal to 0.
- R4: With `cfg_rom_pins` high, an address below 0x000E000 runs a full ROM word cycle, and the read returns 0 whatever the bus drives. With `cfg_rom_pins` low, addresses below 0x0200000 behave as R3.
- R5: A word cycle holds its chip select low for 8 clocks, starting the clock after acceptance. The output strobe (read) or write strobe (write) is low in clocks 2 to 7, which makes 6 clocks. Read data is the value of `bus_din` in clock 7.
- R6: `bus_addr` equals `req_addr[20:0]` from the first chip-select clock onward. It stays there after the strobe rises until the next request is accepted.
- R7: During a write, `bus_doe` is high in every chip-select clock. In a word write, `bus_dout` equals the write data. `bus_doe` is low during reads.
- R8: `cfg_byte_sram` affects only the RAM window. ROM and shadow cycles stay word cycles when it is high.
- R9: A byte-mode read holds the RAM chip select low for 6 clocks. The output strobe is low in clocks 2 to 5. The byte-lane select is low in clocks 1 to 3 and high in clocks 4 to 6. The low byte is `bus_din[7:0]` in clock 3 and the high byte is `bus_din[7:0]` in clock 5. `bus_din[15:8]` is ignored.
- R10: A byte-mode write holds the RAM chip select low for 6 clocks. The write strobe is low in clocks 1, 2, 4 and 5. The byte-lane select is high from clock 3. `bus_dout[7:0]` carries the low byte in clocks 1 to 2 and the high byte in clocks 3 to 6. `bus_dout[15:8]` is 0.
- R11: `req_ready` is low from acceptance through the response clock, so a request held during a cycle is not taken. `rsp_valid` is high for exactly one clock, the last chip-select clock, and `req_ready` returns in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all bus timing counts its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_sram | input | 1 | RAM window uses two byte transfers per word |
| cfg_rom_pins | input | 1 | ROM chip select enabled (window plus shadow range) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | System word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read word, valid with rsp_valid |
| bus_addr | output | 21 | External word address |
| bus_dout | output | 16 | Data driven to the bus |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Data read from the bus |
| bus_rom_cs_n | output | 1 | ROM chip select, active low |
| bus_ram_cs_n | output | 1 | RAM chip select, active low |
| bus_oe_n | output | 1 | Output strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_bsel_n | output | 1 | Byte-lane select, low = low byte |

## Verification
Word reads and writes are aimed at both windows and at the addresses just inside and just outside each edge (0x000DFFF/0x000E000, 0x01FFFFF/0x0200000, 0x21FFFFF/0x2200000). This separates a correct window compare from one that is off by one. The bench memory model returns a different pattern on each byte lane and drives all-ones whenever the output strobe is high. A capture taken in the wrong clock, or from the wrong lane, therefore shows up as a wrong word. The model also puts junk on lines 15:8 in byte mode, which proves those lines are ignored. The byte-mode setting is applied to ROM and shadow accesses to show it leaves them as word cycles. One request is held valid with a different address during a cycle, which shows that the busy controller neither takes it nor lets its address leak onto the bus.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Which external device an access reaches
  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_ROM    = 2'd1,
    RG_RAM    = 2'd2,
    RG_SHADOW = 2'd3
  } region_e;

  // Shape of the bus cycle to run
  typedef enum logic [2:0] {
    CK_NULL    = 3'd0,
    CK_WORD_RD = 3'd1,
    CK_WORD_WR = 3'd2,
    CK_BYTE_RD = 3'd3,
    CK_BYTE_WR = 3'd4
  } cyc_kind_e;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int          ADDR_W = 26,
  parameter logic [25:0] ROM_LO = 26'h000_E000,
  parameter logic [25:0] ROM_HI = 26'h01F_FFFF,
  parameter logic [25:0] RAM_LO = 26'h200_0000,
  parameter logic [25:0] RAM_HI = 26'h21F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_pins,
  input  logic              byte_sram,
  input  logic              write,
  output region_e           region,
  output cyc_kind_e         kind
);

  localparam logic [ADDR_W-1:0] ROM_LO_A = ADDR_W'(ROM_LO);
  localparam logic [ADDR_W-1:0] ROM_HI_A = ADDR_W'(ROM_HI);
  localparam logic [ADDR_W-1:0] RAM_LO_A = ADDR_W'(RAM_LO);
  localparam logic [ADDR_W-1:0] RAM_HI_A = ADDR_W'(RAM_HI);

  logic in_rom, in_ram, below_rom;

  always_comb begin
    in_rom    = (addr >= ROM_LO_A) && (addr <= ROM_HI_A);
    in_ram    = (addr >= RAM_LO_A) && (addr <= RAM_HI_A);
    below_rom = (addr < ROM_LO_A);

    if (in_ram)                     region = RG_RAM;
    else if (rom_pins && in_rom)    region = RG_ROM;
    else if (rom_pins && below_rom) region = RG_SHADOW;
    else                            region = RG_NONE;

    unique case (region)
      RG_NONE: kind = CK_NULL;
      RG_RAM:  kind = byte_sram ? (write ? CK_BYTE_WR : CK_BYTE_RD)
                                : (write ? CK_WORD_WR : CK_WORD_RD);
      default: kind = write ? CK_WORD_WR : CK_WORD_RD;
    endcase
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WORD_STRB  = 6,
  parameter int BYTE_PULSE = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_e kind_in,
  output logic      busy,
  output logic      sel_on,
  output logic      rsp,
  output logic      rd_strb,
  output logic      wr_strb,
  output logic      bsel_n,
  output logic      hi_lane,
  output logic      cap_word,
  output logic      cap_lo,
  output logic      cap_hi
);

  localparam int WORD_LAST = WORD_STRB + 1;
  localparam int BYTE_LAST = 2 * BYTE_PULSE + 1;
  localparam int MAX_LAST  = (WORD_LAST > BYTE_LAST) ? WORD_LAST : BYTE_LAST;
  localparam int PH_W      = $clog2(MAX_LAST + 1);

  localparam logic [PH_W-1:0] P_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0] P_WSTRB = PH_W'(WORD_STRB);
  localparam logic [PH_W-1:0] P_BP    = PH_W'(BYTE_PULSE);
  localparam logic [PH_W-1:0] P_BP1   = PH_W'(BYTE_PULSE + 1);
  localparam logic [PH_W-1:0] P_BP2   = PH_W'(2 * BYTE_PULSE);

  logic [PH_W-1:0] ph_q, last_ph;
  cyc_kind_e       kind_q;

  always_comb begin
    unique case (kind_q)
      CK_NULL:               last_ph = '0;
      CK_WORD_RD, CK_WORD_WR: last_ph = PH_W'(WORD_LAST);
      default:               last_ph = PH_W'(BYTE_LAST);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph_q   <= '0;
      kind_q <= CK_NULL;
    end else if (start) begin
      busy   <= 1'b1;
      ph_q   <= '0;
      kind_q <= kind_in;
    end else if (busy) begin
      if (ph_q == last_ph) busy <= 1'b0;
      else                 ph_q <= ph_q + P_ONE;
    end
  end

  // Strobe and lane decode from the phase count
  always_comb begin
    sel_on   = busy && (kind_q != CK_NULL);
    rsp      = busy && (ph_q == last_ph);
    rd_strb  = 1'b0;
    wr_strb  = 1'b0;
    bsel_n   = 1'b1;
    hi_lane  = 1'b0;
    cap_word = 1'b0;
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    if (busy) begin
      unique case (kind_q)
        CK_WORD_RD: begin
          rd_strb  = (ph_q >= P_ONE) && (ph_q <= P_WSTRB);
          cap_word = (ph_q == P_WSTRB);
        end
        CK_WORD_WR: wr_strb = (ph_q >= P_ONE) && (ph_q <= P_WSTRB);
        CK_BYTE_RD: begin
          rd_strb = (ph_q >= P_ONE) && (ph_q <= P_BP2);
          bsel_n  = (ph_q >= P_BP1);
          cap_lo  = (ph_q == P_BP);
          cap_hi  = (ph_q == P_BP2);
        end
        CK_BYTE_WR: begin
          wr_strb = (ph_q < P_BP) || ((ph_q >= P_BP1) && (ph_q <= P_BP2));
          bsel_n  = (ph_q >= P_BP);
          hi_lane = (ph_q >= P_BP);
        end
        default: ;
      endcase
    end
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strb && wr_strb));

  // R5
  strobe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb || wr_strb) |-> sel_on);

  // R11
  rsp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp |=> (!busy && !rsp));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp) |=> busy);

endmodule

// File: rtl/xbus_rdcap.sv
module xbus_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              keep,
  input  logic              cap_word,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // Byte mode only fills lanes 0 and 1 from the low data lines
    logic byte_hit;
    assign byte_hit = (i == 0) ? cap_lo : ((i == 1) ? cap_hi : 1'b0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rdata[8*i +: 8] <= '0;
      else if (clear)                 rdata[8*i +: 8] <= '0;
      else if (keep && cap_word)      rdata[8*i +: 8] <= din[8*i +: 8];
      else if (keep && byte_hit)      rdata[8*i +: 8] <= din[7:0];
    end
  end

  // R9
  one_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cap_word, cap_lo, cap_hi}) <= 1);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int BUS_AW     = 21,
  parameter int DATA_W     = 16,
  parameter int WORD_STRB  = 6,
  parameter int BYTE_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_byte_sram,
  input  logic              cfg_rom_pins,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_rom_cs_n,
  output logic              bus_ram_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_bsel_n
);

  localparam int HALF = DATA_W / 2;

  region_e           dec_region, region_q;
  cyc_kind_e         dec_kind;
  logic              accept, write_q;
  logic [BUS_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic busy, sel_on, rsp, rd_strb, wr_strb, bsel_n, hi_lane;
  logic cap_word, cap_lo, cap_hi, byte_wr;

  assign accept = req_valid && req_ready;

  xbus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (req_addr),
    .rom_pins  (cfg_rom_pins),
    .byte_sram (cfg_byte_sram),
    .write     (req_write),
    .region    (dec_region),
    .kind      (dec_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= RG_NONE;
      write_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      byte_wr  <= 1'b0;
    end else if (accept) begin
      region_q <= dec_region;
      write_q  <= req_write;
      addr_q   <= req_addr[BUS_AW-1:0];
      wdata_q  <= req_wdata;
      byte_wr  <= (dec_kind == CK_BYTE_WR);
    end
  end

  xbus_seq #(.WORD_STRB(WORD_STRB), .BYTE_PULSE(BYTE_PULSE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .kind_in  (dec_kind),
    .busy     (busy),
    .sel_on   (sel_on),
    .rsp      (rsp),
    .rd_strb  (rd_strb),
    .wr_strb  (wr_strb),
    .bsel_n   (bsel_n),
    .hi_lane  (hi_lane),
    .cap_word (cap_word),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi)
  );

  xbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .keep     (region_q != RG_SHADOW),
    .cap_word (cap_word),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .din      (bus_din),
    .rdata    (rsp_rdata)
  );

  always_comb begin
    req_ready    = !busy;
    rsp_valid    = rsp;
    bus_addr     = addr_q;
    bus_rom_cs_n = !(sel_on && ((region_q == RG_ROM) || (region_q == RG_SHADOW)));
    bus_ram_cs_n = !(sel_on && (region_q == RG_RAM));
    bus_oe_n     = !rd_strb;
    bus_we_n     = !wr_strb;
    bus_bsel_n   = bsel_n;
    bus_doe      = sel_on && write_q;
    if (byte_wr)
      bus_dout = {{HALF{1'b0}}, hi_lane ? wdata_q[DATA_W-1:HALF] : wdata_q[HALF-1:0]};
    else
      bus_dout = wdata_q;
  end

  // R2
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rom_cs_n && !bus_ram_cs_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));

  // R7
  doe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_rom_cs_n || !bus_ram_cs_n));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_dout));

endmodule

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_byte_sram = 1'b0;
  logic        cfg_rom_pins = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_doe;
  logic [15:0] rsp_rdata, bus_dout, bus_din;
  logic [20:0] bus_addr;
  logic        bus_rom_cs_n, bus_ram_cs_n, bus_oe_n, bus_we_n, bus_bsel_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte_sram(cfg_byte_sram), .cfg_rom_pins(cfg_rom_pins),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rom_cs_n(bus_rom_cs_n),
    .bus_ram_cs_n(bus_ram_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_bsel_n(bus_bsel_n)
  );

  function automatic logic [15:0] mem_word(input logic [20:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  // External memory model: all-ones unless a device is strobed
  always_comb begin
    bus_din = 16'hFFFF;
    if (!bus_oe_n && !bus_rom_cs_n)
      bus_din = mem_word(bus_addr);
    else if (!bus_oe_n && !bus_ram_cs_n)
      bus_din = cfg_byte_sram ? {8'h5A, bus_bsel_n ? mem_word(bus_addr)[15:8]
                                                   : mem_word(bus_addr)[7:0]}
                              : mem_word(bus_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transfer, compared clock by clock with the shape the requirements give
  task automatic xfer(input string req, input bit wr, input logic [25:0] a,
                      input logic [15:0] wd, input bit bytecfg, input bit rompins,
                      input bit hold_valid);
    int rg;     // 0 none, 1 rom, 2 ram, 3 shadow
    int cls;    // 0 null, 1 word, 2 byte
    int last;
    logic [15:0] exp_rd;
    rg = 0;
    if (a >= 26'h200_0000 && a <= 26'h21F_FFFF) rg = 2;
    else if (rompins && a >= 26'h000_E000 && a <= 26'h01F_FFFF) rg = 1;
    else if (rompins && a < 26'h000_E000) rg = 3;
    cls  = (rg == 0) ? 0 : ((rg == 2 && bytecfg) ? 2 : 1);
    last = (cls == 0) ? 0 : ((cls == 1) ? 7 : 5);
    exp_rd = (rg == 1 || rg == 2) ? mem_word(a[20:0]) : 16'h0000;

    @(negedge clk);
    cfg_byte_sram = bytecfg;
    cfg_rom_pins  = rompins;
    req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, {req, " R11 ready before"}, req_ready, 1);
    @(negedge clk);
    if (hold_valid) begin
      req_addr = a ^ 26'h000_0F0F; req_wdata = ~wd;
    end else req_valid = 1'b0;
    for (int k = 0; k <= last + 1; k++) begin
      bit in_cyc, e_rom, e_ram, e_oe, e_we, e_bsel_n;
      in_cyc = (k <= last);
      if (k == last) req_valid = 1'b0;
      e_rom = in_cyc && (rg == 1 || rg == 3);
      e_ram = in_cyc && (rg == 2);
      e_oe = 0; e_we = 0; e_bsel_n = 1;
      if (in_cyc && cls == 1) begin
        if (!wr) e_oe = (k >= 1 && k <= 6); else e_we = (k >= 1 && k <= 6);
      end
      if (in_cyc && cls == 2) begin
        if (!wr) begin e_oe = (k >= 1 && k <= 4); e_bsel_n = (k >= 3); end
        else begin e_we = (k == 0 || k == 1 || k == 3 || k == 4); e_bsel_n = (k >= 2); end
      end
      chk(bus_rom_cs_n == !e_rom, {req, " R2 rom cs"}, bus_rom_cs_n, !e_rom);
      chk(bus_ram_cs_n == !e_ram, {req, " R2 ram cs"}, bus_ram_cs_n, !e_ram);
      chk(bus_oe_n == !e_oe, {req, " R5 oe"}, bus_oe_n, !e_oe);
      chk(bus_we_n == !e_we, {req, " R5 we"}, bus_we_n, !e_we);
      chk(bus_bsel_n == e_bsel_n, {req, " R9 bsel"}, bus_bsel_n, e_bsel_n);
      chk(req_ready == !in_cyc, {req, " R11 ready"}, req_ready, !in_cyc);
      chk(rsp_valid == (k == last), {req, " R11 rsp"}, rsp_valid, (k == last));
      chk(bus_doe == (in_cyc && wr && cls != 0), {req, " R7 doe"}, bus_doe,
          (in_cyc && wr && cls != 0));
      if (cls != 0)
        chk(bus_addr == a[20:0], {req, " R6 addr"}, bus_addr, a[20:0]);
      if (in_cyc && wr && cls == 1)
        chk(bus_dout == wd, {req, " R7 dout"}, bus_dout, wd);
      if (in_cyc && wr && cls == 2)
        chk(bus_dout == {8'h00, (k < 2) ? wd[7:0] : wd[15:8]}, {req, " R10 dout"},
            bus_dout, {8'h00, (k < 2) ? wd[7:0] : wd[15:8]});
      if (k == last && !wr)
        chk(rsp_rdata == exp_rd, {req, " R5 rdata"}, rsp_rdata, exp_rd);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(bus_rom_cs_n && bus_ram_cs_n && bus_oe_n && bus_we_n && bus_bsel_n,
        "R1 strobes idle in reset", {bus_rom_cs_n, bus_ram_cs_n, bus_oe_n, bus_we_n, bus_bsel_n}, 5'h1F);
    chk(!bus_doe && !rsp_valid && req_ready, "R1 handshake in reset",
        {bus_doe, rsp_valid, req_ready}, 3'b001);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(bus_rom_cs_n && bus_ram_cs_n && bus_oe_n && bus_we_n && bus_bsel_n && req_ready,
        "R1 idle after reset", {bus_rom_cs_n, bus_ram_cs_n, bus_oe_n, bus_we_n, req_ready}, 5'h1F);
  endtask

  task automatic t_word_rom();
    xfer("R2 rom lo edge read", 0, 26'h000_E000, 16'h0, 0, 1, 0);
    xfer("R5 rom hi edge read", 0, 26'h01F_FFFF, 16'h0, 0, 1, 0);
    xfer("R7 rom word write", 1, 26'h012_3456, 16'hBEEF, 0, 1, 0);
  endtask

  task automatic t_word_ram();
    xfer("R2 ram lo edge read", 0, 26'h200_0000, 16'h0, 0, 0, 0);
    xfer("R2 ram hi edge write", 1, 26'h21F_FFFF, 16'hC0DE, 0, 0, 0);
  endtask

  task automatic t_unmapped();
    xfer("R3 gap read", 0, 26'h020_0000, 16'h0, 0, 1, 0);
    xfer("R3 above ram write", 1, 26'h220_0000, 16'h1234, 0, 1, 0);
  endtask

  task automatic t_shadow();
    xfer("R4 shadow read", 0, 26'h000_DFFF, 16'h0, 0, 1, 0);
    xfer("R4 rom pins off", 0, 26'h000_E000, 16'h0, 0, 0, 0);
    xfer("R4 rom pins off low", 1, 26'h000_0100, 16'h7777, 0, 0, 0);
  endtask

  task automatic t_byte();
    xfer("R9 byte read", 0, 26'h200_1A2B, 16'h0, 1, 0, 0);
    xfer("R10 byte write", 1, 26'h210_0042, 16'hA55A, 1, 0, 0);
    xfer("R8 byte cfg rom", 0, 26'h003_4567, 16'h0, 1, 1, 0);
    xfer("R8 byte cfg shadow", 0, 26'h000_8001, 16'h0, 1, 1, 0);
  endtask

  task automatic t_backpressure();
    xfer("R11 held word read", 0, 26'h200_0F00, 16'h0, 0, 0, 1);
    xfer("R11 held byte write", 1, 26'h200_00F0, 16'h9183, 1, 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_word_rom();
    t_word_ram();
    t_unmapped();
    t_shadow();
    t_byte();
    t_backpressure();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule